// File: doc/BRIEF.md
# Elliptic-Curve Accelerator Register Front-End

This block is the register-side front-end of an elliptic-curve arithmetic accelerator. A host reaches it over a simple 32-bit register bus that has a byte address, a write enable, write data and registered read data. The block stores the scalar and the two point coordinates in three parameter memories. It also holds a configuration and control word, a done interrupt with a raw bit, a mask and a clear register, and a fixed version word.

On the engine side the block issues a one-cycle start pulse and presents the work mode and key length. A second port lets the engine read and overwrite parameter words. The engine writes its results over the input-point memories, so the host reads the result coordinates from the addresses it used for the input point. When the engine finishes it returns a done pulse and a verification flag. The block turns the pulse into a sticky interrupt and, for the verifying modes, keeps the flag as a read-only bit.

Top module: `ec_accel_regs`

## Requirements
- R1: After a synchronous reset every register and parameter word reads 0, except the version word at 0x0FC, which reads 0x2012230 in bits 27:0. The engine word count is 6 after reset.
- R2: The scalar memory is at 0x100, the first coordinate at 0x120 and the second coordinate at 0x140. Each memory has eight 32-bit words, with word i at base+4*i. Address bits 1:0 are ignored. Read data appears on the cycle after the address is presented.
- R3: When the block is idle, writing 0x1C with bit 0 set raises eng_start for exactly one cycle, the cycle after the write. Bit 0 of 0x1C then reads 1 until the engine reports done.
- R4: A start write while an operation is busy produces no start pulse.
- R5: A done pulse during a busy operation sets bit 0 of 0x0C and ends the busy state. The bit stays set until it is cleared.
- R6: Bit 0 of 0x10 reads as (bit 0 of 0x0C) AND (bit 0 of 0x14). The mask bit at 0x14 can be read and written.
- R7: Writing 1 to bit 0 of 0x18 clears the raw done bit, and 0x18 always reads 0. If a done pulse arrives in the same cycle as the clear, the raw bit stays set.
- R8: Bit 8 of 0x1C holds the engine's verification flag. On done it is loaded when the mode field is 2 (curve check) or 3 (check then multiply). In mode 0 (multiply) or mode 1 (inverse multiply) it is left unchanged. A start clears it.
- R9: Writing 0x1C with bit 1 set aborts a busy operation and clears the raw done bit and the verification flag. It leaves the parameter memories alone. Bit 1 always reads 0, and a done pulse arriving after the abort has no effect.
- R10: Bus writes to the parameter memories are ignored while busy. Engine writes through the engine port are visible to later bus reads.
- R11: 0x1C holds the key-length bit (bit 2), the security bit (3), the clock-enable bit (4) and the mode (bits 7:5), and reads them back. eng_mode follows the mode field and eng_long_key follows bit 2. eng_nwords is 8 when bit 2 is 1 and 6 when it is 0.
- R12: eng_prdata returns the parameter word selected by eng_paddr on the previous cycle, where eng_paddr is {bank[1:0], word[2:0]} with bank 0 = scalar, 1 = first coordinate and 2 = second coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_mode | output | 3 | Work mode selected for the engine |
| eng_long_key | output | 1 | 1 for the 256-bit curve, 0 for the 192-bit curve |
| eng_nwords | output | clog2(NWORDS+1) | Number of words per operand in use |
| eng_paddr | input | clog2(NWORDS)+2 | Engine parameter select {bank, word} |
| eng_pwe | input | 1 | Engine parameter write strobe |
| eng_pwdata | input | DATA_W | Engine parameter write data |
| eng_prdata | output | DATA_W | Registered engine parameter read data |
| eng_done | input | 1 | Engine completion pulse |
| eng_verify | input | 1 | Engine verification flag, sampled with done |

## Verification
Each result of this block arrives exactly one clock edge after its cause. Read data reflects the address and state seen at the edge that follows the address. eng_start rises on the edge that takes the start write. The interrupt, busy and verification bits change on the edge that takes the done pulse, the clear or the abort, so a read issued in the next cycle returns the new value one edge later. The bench drives inputs just after the falling edge and steps its behavioural model at the rising edge using those same inputs. It compares all outputs at the next falling edge, which matches that one-edge latency for every result. It also checks known constants at chosen moments, including a done pulse and a clear write in the same cycle, and a done pulse that arrives after an abort.

// File: rtl/ec_regs_pkg.sv
package ec_regs_pkg;

  // byte offsets of the control registers (12-bit address space)
  localparam logic [11:0] OFS_RAW    = 12'h00C;
  localparam logic [11:0] OFS_STATUS = 12'h010;
  localparam logic [11:0] OFS_MASK   = 12'h014;
  localparam logic [11:0] OFS_CLEAR  = 12'h018;
  localparam logic [11:0] OFS_CTRL   = 12'h01C;
  localparam logic [11:0] OFS_VER    = 12'h0FC;
  localparam logic [11:0] PARAM_BASE = 12'h100;

  // bit positions inside the control word
  localparam int unsigned CTL_GO_BIT     = 0;
  localparam int unsigned CTL_ABORT_BIT  = 1;
  localparam int unsigned CTL_LONG_BIT   = 2;
  localparam int unsigned CTL_SECURE_BIT = 3;
  localparam int unsigned CTL_CKEN_BIT   = 4;
  localparam int unsigned CTL_MODE_LSB   = 5;
  localparam int unsigned CTL_VERIFY_BIT = 8;

  // work modes
  localparam logic [2:0] MODE_MUL      = 3'd0;
  localparam logic [2:0] MODE_INV_MUL  = 3'd1;
  localparam logic [2:0] MODE_CHECK    = 3'd2;
  localparam logic [2:0] MODE_CHK_MUL  = 3'd3;

  typedef struct packed {
    logic [2:0] mode;
    logic       clk_en;
    logic       secure;
    logic       long_key;
  } ec_ctrl_t;

endpackage

// File: rtl/ec_param_bank.sv
module ec_param_bank #(
  parameter int unsigned NWORDS = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [NWORDS-1:0][DATA_W-1:0] words;

  // engine port wins on a same-word collision
  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (eng_we && eng_idx == IDX_W'(w)) begin
          words[w] <= eng_wdata;
        end else if (bus_we && bus_idx == IDX_W'(w)) begin
          words[w] <= bus_wdata;
        end
      end
    end
  end

  assign rd_a = words[bus_idx];
  assign rd_b = words[eng_idx];

  p_eng_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
    eng_we |=> (words[$past(eng_idx)] == $past(eng_wdata)));

endmodule

// File: rtl/ec_ctrl_unit.sv
module ec_ctrl_unit
  import ec_regs_pkg::*;
#(
  parameter int unsigned NWORDS      = 8,
  parameter int unsigned SHORT_WORDS = 6,
  localparam int unsigned NW_W = $clog2(NWORDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            wr_go,
  input  logic            wr_abort,
  input  ec_ctrl_t        wr_fields,
  input  logic            eng_done,
  input  logic            eng_verify,
  output ec_ctrl_t        ctrl_q,
  output logic            busy_q,
  output logic            start_q,
  output logic            verify_q,
  output logic [NW_W-1:0] nwords_q,
  output logic            done_evt,
  output logic            abort_evt
);

  logic go_evt;
  logic verify_mode;

  assign abort_evt   = ctrl_we && wr_abort;
  assign go_evt      = ctrl_we && wr_go && !busy_q && !abort_evt;
  assign done_evt    = eng_done && busy_q && !abort_evt;
  assign verify_mode = (ctrl_q.mode == MODE_CHECK) || (ctrl_q.mode == MODE_CHK_MUL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      verify_q <= 1'b0;
      nwords_q <= NW_W'(SHORT_WORDS);
    end else begin
      start_q <= go_evt;

      if (abort_evt || done_evt) begin
        busy_q <= 1'b0;
      end else if (go_evt) begin
        busy_q <= 1'b1;
      end

      if (abort_evt || go_evt) begin
        verify_q <= 1'b0;
      end else if (done_evt && verify_mode) begin
        verify_q <= eng_verify;
      end

      if (ctrl_we) begin
        ctrl_q   <= wr_fields;
        nwords_q <= wr_fields.long_key ? NW_W'(NWORDS) : NW_W'(SHORT_WORDS);
      end
    end
  end

  p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);

  p_busy_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ctrl_we && wr_go && !abort_evt && !eng_done) |=> (busy_q && !start_q));

  p_verify_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (done_evt && !verify_mode) |=> $stable(verify_q));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (!busy_q && !verify_q));

endmodule

// File: rtl/ec_irq_regs.sv
module ec_irq_regs (
  input  logic clk,
  input  logic rst,
  input  logic done_evt,
  input  logic abort_evt,
  input  logic mask_we,
  input  logic clear_we,
  input  logic wbit,
  output logic raw_q,
  output logic mask_q,
  output logic status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (abort_evt) begin
        raw_q <= 1'b0;
      end else if (done_evt) begin
        raw_q <= 1'b1;
      end else if (clear_we && wbit) begin
        raw_q <= 1'b0;
      end
      if (mask_we) begin
        mask_q <= wbit;
      end
    end
  end

  assign status = raw_q && mask_q;

  p_done_sets_raw_r5: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> raw_q);

  p_raw_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !abort_evt && !(clear_we && wbit)) |=> raw_q);

  p_clear_drops_raw_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_we && wbit && !done_evt && !abort_evt) |=> !raw_q);

endmodule

// File: rtl/ec_accel_regs.sv
module ec_accel_regs
  import ec_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NWORDS      = 8,
  parameter int unsigned SHORT_WORDS = 6,
  parameter logic [27:0] VERSION     = 28'h2012230
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         eng_start,
  output logic [2:0]                   eng_mode,
  output logic                         eng_long_key,
  output logic [$clog2(NWORDS+1)-1:0]  eng_nwords,
  input  logic [$clog2(NWORDS)+1:0]    eng_paddr,
  input  logic                         eng_pwe,
  input  logic [DATA_W-1:0]            eng_pwdata,
  output logic [DATA_W-1:0]            eng_prdata,
  input  logic                         eng_done,
  input  logic                         eng_verify
);

  localparam int unsigned IDX_W    = $clog2(NWORDS);
  localparam int unsigned NBANKS   = 3;
  localparam int unsigned SPAN_LSB = IDX_W + 2;
  localparam int unsigned NW_W     = $clog2(NWORDS + 1);
  localparam logic [11:0] PARAM_BYTES = 12'(NBANKS * NWORDS * 4);

  // ---------------- address decode ----------------
  logic [11:0]      addr12;
  logic [11:0]      poff;
  logic             p_hit;
  logic [1:0]       p_bank;
  logic [IDX_W-1:0] p_idx;
  logic [1:0]       e_bank;
  logic [IDX_W-1:0] e_idx;
  logic             ctrl_we, mask_we, clear_we;

  assign addr12   = 12'(bus_addr);
  assign poff     = addr12 - PARAM_BASE;
  assign p_hit    = (addr12 >= PARAM_BASE) && (poff < PARAM_BYTES);
  assign p_bank   = poff[SPAN_LSB +: 2];
  assign p_idx    = poff[2 +: IDX_W];
  assign e_bank   = eng_paddr[IDX_W +: 2];
  assign e_idx    = eng_paddr[IDX_W-1:0];
  assign ctrl_we  = bus_we && (addr12[11:2] == OFS_CTRL[11:2]);
  assign mask_we  = bus_we && (addr12[11:2] == OFS_MASK[11:2]);
  assign clear_we = bus_we && (addr12[11:2] == OFS_CLEAR[11:2]);

  logic unused_addr_bits;
  assign unused_addr_bits = ^{poff[1:0], poff[11:SPAN_LSB+2]};

  // ---------------- control / status ----------------
  ec_ctrl_t ctrl_q;
  ec_ctrl_t wr_fields;
  logic     busy_q, verify_q, done_evt, abort_evt;
  logic     raw_q, mask_q, status;

  assign wr_fields.mode     = bus_wdata[CTL_MODE_LSB +: 3];
  assign wr_fields.clk_en   = bus_wdata[CTL_CKEN_BIT];
  assign wr_fields.secure   = bus_wdata[CTL_SECURE_BIT];
  assign wr_fields.long_key = bus_wdata[CTL_LONG_BIT];

  ec_ctrl_unit #(
    .NWORDS      (NWORDS),
    .SHORT_WORDS (SHORT_WORDS)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .wr_go      (bus_wdata[CTL_GO_BIT]),
    .wr_abort   (bus_wdata[CTL_ABORT_BIT]),
    .wr_fields  (wr_fields),
    .eng_done   (eng_done),
    .eng_verify (eng_verify),
    .ctrl_q     (ctrl_q),
    .busy_q     (busy_q),
    .start_q    (eng_start),
    .verify_q   (verify_q),
    .nwords_q   (eng_nwords),
    .done_evt   (done_evt),
    .abort_evt  (abort_evt)
  );

  ec_irq_regs i_irq (
    .clk       (clk),
    .rst       (rst),
    .done_evt  (done_evt),
    .abort_evt (abort_evt),
    .mask_we   (mask_we),
    .clear_we  (clear_we),
    .wbit      (bus_wdata[0]),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .status    (status)
  );

  assign eng_mode     = ctrl_q.mode;
  assign eng_long_key = ctrl_q.long_key;

  // ---------------- parameter memories ----------------
  logic [DATA_W-1:0] bank_rd_a [4];
  logic [DATA_W-1:0] bank_rd_b [4];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    ec_param_bank #(
      .NWORDS (NWORDS),
      .DATA_W (DATA_W)
    ) i_bank (
      .clk       (clk),
      .rst       (rst),
      .bus_we    (bus_we && p_hit && !busy_q && (p_bank == 2'(b))),
      .bus_idx   (p_idx),
      .bus_wdata (bus_wdata),
      .eng_we    (eng_pwe && (e_bank == 2'(b))),
      .eng_idx   (e_idx),
      .eng_wdata (eng_pwdata),
      .rd_a      (bank_rd_a[b]),
      .rd_b      (bank_rd_b[b])
    );
  end
  assign bank_rd_a[3] = '0;
  assign bank_rd_b[3] = '0;

  // ---------------- read paths ----------------
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (p_hit) begin
      rd_next = bank_rd_a[p_bank];
    end else begin
      case (addr12[11:2])
        OFS_RAW[11:2]:    rd_next[0] = raw_q;
        OFS_STATUS[11:2]: rd_next[0] = status;
        OFS_MASK[11:2]:   rd_next[0] = mask_q;
        OFS_CTRL[11:2]: begin
          rd_next[CTL_GO_BIT]          = busy_q;
          rd_next[CTL_LONG_BIT]        = ctrl_q.long_key;
          rd_next[CTL_SECURE_BIT]      = ctrl_q.secure;
          rd_next[CTL_CKEN_BIT]        = ctrl_q.clk_en;
          rd_next[CTL_MODE_LSB +: 3]   = ctrl_q.mode;
          rd_next[CTL_VERIFY_BIT]      = verify_q;
        end
        OFS_VER[11:2]:    rd_next[27:0] = VERSION;
        default:          rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      eng_prdata <= '0;
    end else begin
      bus_rdata  <= rd_next;
      eng_prdata <= bank_rd_b[e_bank];
    end
  end

  p_nwords_tracks_key_r11: assert property (@(posedge clk) disable iff (rst)
    eng_nwords == (eng_long_key ? NW_W'(NWORDS) : NW_W'(SHORT_WORDS)));

  p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && addr12 == OFS_CLEAR) |=> (bus_rdata == '0));

endmodule

// File: tb/test_ec_accel_regs.sv
module test_ec_accel_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start;
  logic [2:0]  eng_mode;
  logic        eng_long_key;
  logic [3:0]  eng_nwords;
  logic [4:0]  eng_paddr = '0;
  logic        eng_pwe = 1'b0;
  logic [31:0] eng_pwdata = '0;
  logic [31:0] eng_prdata;
  logic        eng_done = 1'b0;
  logic        eng_verify = 1'b0;

  always #10 clk = ~clk;

  ec_accel_regs i_ec_accel_regs (
    .clk (clk), .rst (rst),
    .bus_addr (b_addr), .bus_we (b_we), .bus_wdata (b_wdata), .bus_rdata (bus_rdata),
    .eng_start (eng_start), .eng_mode (eng_mode), .eng_long_key (eng_long_key),
    .eng_nwords (eng_nwords), .eng_paddr (eng_paddr), .eng_pwe (eng_pwe),
    .eng_pwdata (eng_pwdata), .eng_prdata (eng_prdata),
    .eng_done (eng_done), .eng_verify (eng_verify)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_mem [3][8];
  bit          m_busy, m_raw, m_mask, m_ver, m_long, m_sec, m_cken;
  logic [2:0]  m_mode;
  logic [31:0] x_rdata, x_prdata;
  bit          x_start;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    finished = 0;

  function automatic logic [31:0] m_read(logic [8:0] a);
    logic [31:0] v = '0;
    if (a >= 9'h100 && a < 9'h160) begin
      v = m_mem[(a - 9'h100) >> 5][(a >> 2) & 9'd7];
    end else begin
      case ({a[8:2], 2'b00})
        9'h00C: v[0] = m_raw;
        9'h010: v[0] = m_raw & m_mask;
        9'h014: v[0] = m_mask;
        9'h01C: v = {23'd0, m_ver, m_mode, m_cken, m_sec, m_long, 1'b0, m_busy};
        9'h0FC: v = 32'h0201_2230;
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic model_step();
    if (rst) begin
      foreach (m_mem[b, w]) m_mem[b][w] = '0;
      {m_busy, m_raw, m_mask, m_ver, m_long, m_sec, m_cken} = '0;
      m_mode = '0; x_rdata = '0; x_prdata = '0; x_start = 0;
    end else begin
      bit ctl_w, abort, go, dn;
      logic [8:0] aw;
      aw       = {b_addr[8:2], 2'b00};
      x_rdata  = m_read(b_addr);
      x_prdata = (eng_paddr[4:3] < 2'd3) ? m_mem[eng_paddr[4:3]][eng_paddr[2:0]] : '0;
      ctl_w = b_we && aw == 9'h01C;
      abort = ctl_w && b_wdata[1];
      go    = ctl_w && b_wdata[0] && !m_busy && !abort;
      dn    = eng_done && m_busy && !abort;
      x_start = go;
      if (b_we && b_addr >= 9'h100 && b_addr < 9'h160 && !m_busy)
        m_mem[(b_addr - 9'h100) >> 5][(b_addr >> 2) & 9'd7] = b_wdata;
      if (eng_pwe && eng_paddr[4:3] < 2'd3)
        m_mem[eng_paddr[4:3]][eng_paddr[2:0]] = eng_pwdata;
      if (abort || go) m_ver = 0;
      else if (dn && (m_mode == 3'd2 || m_mode == 3'd3)) m_ver = eng_verify;
      if (abort) m_raw = 0;
      else if (dn) m_raw = 1;
      else if (b_we && aw == 9'h018 && b_wdata[0]) m_raw = 0;
      if (b_we && aw == 9'h014) m_mask = b_wdata[0];
      if (abort || dn) m_busy = 0;
      else if (go) m_busy = 1;
      if (ctl_w) begin
        m_mode = b_wdata[7:5]; m_cken = b_wdata[4]; m_sec = b_wdata[3]; m_long = b_wdata[2];
      end
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, bus_rdata, x_rdata);
    chk(cur_req, 32'(eng_start), 32'(x_start));
    chk(cur_req, 32'(eng_mode), 32'(m_mode));
    chk(cur_req, 32'(eng_long_key), 32'(m_long));
    chk(cur_req, 32'(eng_nwords), m_long ? 32'd8 : 32'd6);
    chk(cur_req, eng_prdata, x_prdata);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    b_addr = a; b_we = 1'b1; b_wdata = d;
    cycle();
    b_we = 1'b0; b_wdata = '0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] v);
    b_addr = a;
    cycle();
    v = bus_rdata;
  endtask

  task automatic done_pulse(bit vflag);
    eng_done = 1'b1; eng_verify = vflag;
    cycle();
    eng_done = 1'b0; eng_verify = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) cycle();
    rst = 1'b0;

    // R1: reset state
    cur_req = "R1";
    rd(9'h0FC, v); chk("R1", v, 32'h0201_2230);
    rd(9'h01C, v); chk("R1", v, 32'h0);
    rd(9'h0C0 + 9'h040, v); chk("R1", v, 32'h0);
    chk("R1", 32'(eng_nwords), 32'd6);

    // R2: parameter map and read latency
    cur_req = "R2";
    wr(9'h100, 32'hA5A5_0001);
    wr(9'h13C, 32'h1111_2222);
    wr(9'h154, 32'h3333_4444);
    rd(9'h100, v); chk("R2", v, 32'hA5A5_0001);
    rd(9'h13C, v); chk("R2", v, 32'h1111_2222);
    rd(9'h13E, v); chk("R2", v, 32'h1111_2222);
    rd(9'h154, v); chk("R2", v, 32'h3333_4444);

    // R11: configuration fields
    cur_req = "R11";
    wr(9'h01C, 32'h7C);
    chk("R11", 32'(eng_mode), 32'd3);
    chk("R11", 32'(eng_nwords), 32'd8);
    rd(9'h01C, v); chk("R11", v, 32'h7C);
    wr(9'h01C, 32'h20);
    chk("R11", 32'(eng_nwords), 32'd6);
    chk("R11", 32'(eng_mode), 32'd1);

    // R3: start pulse and busy readback
    cur_req = "R3";
    wr(9'h01C, 32'h01);
    chk("R3", 32'(eng_start), 32'd1);
    cycle();
    chk("R3", 32'(eng_start), 32'd0);
    rd(9'h01C, v); chk("R3", v, 32'h01);

    // R4: start while busy ignored
    cur_req = "R4";
    wr(9'h01C, 32'h01);
    chk("R4", 32'(eng_start), 32'd0);

    // R10: bus writes blocked while busy; engine results visible
    cur_req = "R10";
    wr(9'h120, 32'hDEAD_0000);
    eng_pwe = 1'b1; eng_paddr = {2'd1, 3'd1}; eng_pwdata = 32'hCAFE_0001;
    cycle();
    eng_paddr = {2'd2, 3'd1}; eng_pwdata = 32'hCAFE_0002;
    cycle();
    eng_pwe = 1'b0;
    rd(9'h120, v); chk("R10", v, 32'h0);
    rd(9'h124, v); chk("R10", v, 32'hCAFE_0001);

    // R12: engine read port
    cur_req = "R12";
    eng_paddr = {2'd2, 3'd1};
    cycle();
    chk("R12", eng_prdata, 32'hCAFE_0002);
    eng_paddr = {2'd0, 3'd0};
    cycle();
    chk("R12", eng_prdata, 32'hA5A5_0001);

    // R5: done sets sticky raw bit, ends busy
    cur_req = "R5";
    done_pulse(1'b0);
    rd(9'h00C, v); chk("R5", v, 32'h1);
    repeat (3) cycle();
    rd(9'h00C, v); chk("R5", v, 32'h1);
    rd(9'h01C, v); chk("R5", v, 32'h0);

    // R6: masked status
    cur_req = "R6";
    rd(9'h010, v); chk("R6", v, 32'h0);
    wr(9'h014, 32'h1);
    rd(9'h010, v); chk("R6", v, 32'h1);
    rd(9'h014, v); chk("R6", v, 32'h1);

    // R7: clear, and done beating a same-cycle clear
    cur_req = "R7";
    wr(9'h018, 32'h1);
    rd(9'h00C, v); chk("R7", v, 32'h0);
    rd(9'h018, v); chk("R7", v, 32'h0);
    rd(9'h010, v); chk("R7", v, 32'h0);
    wr(9'h01C, 32'h01);
    b_addr = 9'h018; b_we = 1'b1; b_wdata = 32'h1; eng_done = 1'b1;
    cycle();
    b_we = 1'b0; b_wdata = '0; eng_done = 1'b0;
    rd(9'h00C, v); chk("R7", v, 32'h1);

    // R8: verification flag per mode
    cur_req = "R8";
    wr(9'h018, 32'h1);
    wr(9'h01C, 32'h41);
    done_pulse(1'b1);
    rd(9'h01C, v); chk("R8", v, 32'h140);
    wr(9'h01C, 32'h01);
    rd(9'h01C, v); chk("R8", v, 32'h01);
    done_pulse(1'b1);
    rd(9'h01C, v); chk("R8", v, 32'h00);
    wr(9'h01C, 32'h61);
    done_pulse(1'b1);
    rd(9'h01C, v); chk("R8", v, 32'h160);

    // R9: abort clears raw/verify, keeps parameters
    cur_req = "R9";
    wr(9'h01C, 32'h62);
    rd(9'h01C, v); chk("R9", v, 32'h60);
    rd(9'h00C, v); chk("R9", v, 32'h0);
    wr(9'h01C, 32'h01);
    rd(9'h01C, v); chk("R9", v, 32'h01);
    wr(9'h01C, 32'h02);
    rd(9'h01C, v); chk("R9", v, 32'h00);
    done_pulse(1'b1);
    rd(9'h00C, v); chk("R9", v, 32'h0);
    rd(9'h124, v); chk("R9", v, 32'hCAFE_0001);
    rd(9'h100, v); chk("R9", v, 32'hA5A5_0001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule